// File: doc/BRIEF.md
# Processor Operating Mode Controller

This block keeps the mode-control state of a processor core: protection enable, paging enable, address-extension enable, long-mode enable and the long-mode-active status bit. Software changes the control bits through a small write port (a target select, a data word and a strobe). Writes that would break the ordering rules between these bits are refused. A refused write changes nothing and raises a one-cycle fault pulse.

The active status bit cannot be written. It comes on only when paging is switched on while long mode is already enabled, and it goes off in the same update that turns paging off.

From the held state and the L and D bits of the current code-segment descriptor, the block decodes the operating mode and reports the effective operand and address sizes. These sizes take the operand-size override, the address-size override and a wide-operand request into account. The instruction front end uses them directly.

Top module: `opmode_ctl`

## Requirements
- R1: After a synchronous active-low reset, all five state bits read 0, the fault output is 0, and the block reports real mode with 16-bit operand and address sizes.
- R2: On an accepted write, the state updates at the next clock edge. Target select 0 writes protection enable from data bit 0 and paging enable from data bit 1. Select 1 writes address-extension enable from bit 0. Select 2 writes long-mode enable from bit 0. Select 3 is ignored, changes no bit and raises no fault.
- R3: Writing long-mode enable alone leaves the active bit at 0. The active bit becomes 1 only when a write that turns paging on is accepted while long-mode enable is 1. Paging turned on with long-mode enable at 0 leaves the active bit at 0. A write that clears paging clears the active bit at the same edge.
- R4: A select-0 write that requests paging 1 together with protection 0 is refused.
- R5: A select-0 write that turns paging from 0 to 1 while long-mode enable is 1 and address-extension enable is 0 is refused.
- R6: A select-2 write that changes long-mode enable while paging is 1 is refused. A select-1 write that clears address-extension enable while paging and long-mode enable are both 1 is refused. The same writes are accepted once paging is 0.
- R7: A refused write leaves every state bit unchanged. The fault output is 1 for exactly the one cycle that follows the edge at which the write was presented.
- R8: Mode codes are 0 real, 1 legacy protected, 2 compatibility and 3 64-bit. Size codes are 0 for 16, 1 for 32 and 2 for 64. With protection enable 0 the mode is 0. Sizes default to 16, each override turns its own size to 32, and L, D and the wide request are ignored.
- R9: With protection 1 and the active bit 0, the mode is 1 and L is ignored. D=1 gives 32/32 and D=0 gives 16/16. Each override toggles its own size between 16 and 32. The wide request is ignored.
- R10: With the active bit 1 and L=0, the mode is 2 and sizes follow the rule of R9.
- R11: With the active bit 1, L=1 and D=0, the mode is 3. Operand size defaults to 32, becomes 16 with the operand override, and becomes 64 with the wide request, which wins over the override. Address size defaults to 64 and becomes 32 with the address override.
- R12: With the active bit 1, L=1 and D=1 (the reserved encoding), the invalid flag is 1, and the mode and sizes are as in R11. In every other case the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | SEL_W | Write target select |
| wr_data | input | DATA_W | Write data |
| cs_l | input | 1 | Code-segment L bit |
| cs_d | input | 1 | Code-segment D bit |
| osz_ovr | input | 1 | Operand-size override present |
| asz_ovr | input | 1 | Address-size override present |
| wide_op | input | 1 | Wide (64-bit) operand request |
| mode_o | output | 2 | Operating mode code |
| op_size_o | output | 2 | Effective operand size code |
| addr_size_o | output | 2 | Effective address size code |
| mode_invalid_o | output | 1 | Reserved code-segment encoding in long mode |
| fault_o | output | 1 | One-cycle pulse on a refused write |
| prot_en_o | output | 1 | Protection enable |
| page_en_o | output | 1 | Paging enable |
| addr_ext_o | output | 1 | Address-extension enable |
| long_en_o | output | 1 | Long-mode enable |
| long_act_o | output | 1 | Long-mode active status |

## Verification
The bench builds the block with its default parameters: a 2-bit select and a 2-bit data word. That makes every write target and every data value cheap to reach. In each reachable combination of protection and active state, the bench sweeps all 32 combinations of L, D and the three override inputs, so every decode row and every override interaction is compared against sizes the bench computes itself. A scripted write sequence walks through each refused and each accepted transition of the state bits, including the writes that switch long mode on and off.

// File: rtl/opmode_pkg.sv
// Package: shared types for the operating mode controller.
// Assumes: 2-bit mode and size codes as listed in the brief.
package opmode_pkg;

    typedef enum logic [1:0] {
        OPM_REAL   = 2'd0,
        OPM_PROT   = 2'd1,
        OPM_COMPAT = 2'd2,
        OPM_WIDE   = 2'd3
    } opm_mode_e;

    typedef enum logic [1:0] {
        SZ_16 = 2'd0,
        SZ_32 = 2'd1,
        SZ_64 = 2'd2
    } opm_size_e;

    typedef struct packed {
        logic prot;
        logic page;
        logic ext;
        logic lng;
        logic act;
    } opm_state_t;

    localparam int unsigned SEL_CTRL = 0;
    localparam int unsigned SEL_EXT  = 1;
    localparam int unsigned SEL_LONG = 2;

endpackage

// File: rtl/opmode_regs.sv
// Module: state bits plus the write-legality rules.
// Assumes: one write per cycle; a refused write leaves state untouched and
// raises fault on the following cycle only. The active bit is never written.
module opmode_regs
    import opmode_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int DATA_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output opm_state_t        state,
    output logic              fault
);

    localparam int PROT_BIT = 0;
    localparam int PAGE_BIT = 1;
    localparam int EXT_BIT  = 0;
    localparam int LONG_BIT = 0;

    opm_state_t cur_q, nxt;
    logic       reject;
    logic       req_prot, req_page, req_ext, req_long;

    // Pull the requested field values out of the data word.
    always_comb begin
        req_prot = wr_data[PROT_BIT];
        req_page = wr_data[PAGE_BIT];
        req_ext  = wr_data[EXT_BIT];
        req_long = wr_data[LONG_BIT];
    end

    // Apply the ordering rules and form the next state.
    always_comb begin
        nxt    = cur_q;
        reject = 1'b0;
        if (wr_en) begin
            if (wr_sel == SEL_W'(SEL_CTRL)) begin
                if (req_page && !req_prot) begin
                    reject = 1'b1;
                end else if (req_page && !cur_q.page && cur_q.lng && !cur_q.ext) begin
                    reject = 1'b1;
                end else begin
                    nxt.prot = req_prot;
                    nxt.page = req_page;
                    nxt.act  = req_page & cur_q.lng;
                end
            end else if (wr_sel == SEL_W'(SEL_EXT)) begin
                if (!req_ext && cur_q.page && cur_q.lng) begin
                    reject = 1'b1;
                end else begin
                    nxt.ext = req_ext;
                end
            end else if (wr_sel == SEL_W'(SEL_LONG)) begin
                if ((req_long != cur_q.lng) && cur_q.page) begin
                    reject = 1'b1;
                end else begin
                    nxt.lng = req_long;
                end
            end
        end
    end

    // Hold the state bits; reset puts the block in real mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt;
        end
    end

    // Register the refusal as a one-cycle fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault <= 1'b0;
        end else begin
            fault <= reject;
        end
    end

    assign state = cur_q;

endmodule

// File: rtl/opmode_decode.sv
// Module: derive operating mode and the reserved-encoding flag.
// Assumes: active bit only set with protection on (guaranteed by opmode_regs).
module opmode_decode
    import opmode_pkg::*;
(
    input  logic      prot,
    input  logic      act,
    input  logic      cs_l,
    input  logic      cs_d,
    output opm_mode_e mode,
    output logic      invalid
);

    // Select the mode row from protection, active bit and descriptor bits.
    always_comb begin
        invalid = 1'b0;
        if (!prot) begin
            mode = OPM_REAL;
        end else if (!act) begin
            mode = OPM_PROT;
        end else if (!cs_l) begin
            mode = OPM_COMPAT;
        end else begin
            mode    = OPM_WIDE;
            invalid = cs_d;
        end
    end

endmodule

// File: rtl/opmode_size.sv
// Module: effective operand and address sizes from mode and prefixes.
// Assumes: in the 64-bit row the wide request outranks the operand override.
module opmode_size
    import opmode_pkg::*;
(
    input  opm_mode_e mode,
    input  logic      cs_d,
    input  logic      osz_ovr,
    input  logic      asz_ovr,
    input  logic      wide_op,
    output opm_size_e op_size,
    output opm_size_e addr_size
);

    opm_size_e base;

    // Default size for the 16/32 rows: real is fixed at 16, others follow D.
    always_comb begin
        if (mode == OPM_REAL) begin
            base = SZ_16;
        end else begin
            base = cs_d ? SZ_32 : SZ_16;
        end
    end

    // Apply prefixes to form the effective sizes.
    always_comb begin
        if (mode == OPM_WIDE) begin
            if (wide_op) begin
                op_size = SZ_64;
            end else begin
                op_size = osz_ovr ? SZ_16 : SZ_32;
            end
            addr_size = asz_ovr ? SZ_32 : SZ_64;
        end else begin
            op_size   = osz_ovr ? ((base == SZ_32) ? SZ_16 : SZ_32) : base;
            addr_size = asz_ovr ? ((base == SZ_32) ? SZ_16 : SZ_32) : base;
        end
    end

endmodule

// File: rtl/opmode_ctl.sv
// Module: top of the operating mode controller.
// Assumes: descriptor bits and prefix inputs are stable for the cycle they
// are used; outputs of the decode are combinational from held state.
module opmode_ctl
    import opmode_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int DATA_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cs_l,
    input  logic              cs_d,
    input  logic              osz_ovr,
    input  logic              asz_ovr,
    input  logic              wide_op,
    output logic [1:0]        mode_o,
    output logic [1:0]        op_size_o,
    output logic [1:0]        addr_size_o,
    output logic              mode_invalid_o,
    output logic              fault_o,
    output logic              prot_en_o,
    output logic              page_en_o,
    output logic              addr_ext_o,
    output logic              long_en_o,
    output logic              long_act_o
);

    opm_state_t st;
    opm_mode_e  mode;
    opm_size_e  op_sz, ad_sz;

    opmode_regs #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .state   (st),
        .fault   (fault_o)
    );

    opmode_decode u_dec (
        .prot    (st.prot),
        .act     (st.act),
        .cs_l    (cs_l),
        .cs_d    (cs_d),
        .mode    (mode),
        .invalid (mode_invalid_o)
    );

    opmode_size u_size (
        .mode      (mode),
        .cs_d      (cs_d),
        .osz_ovr   (osz_ovr),
        .asz_ovr   (asz_ovr),
        .wide_op   (wide_op),
        .op_size   (op_sz),
        .addr_size (ad_sz)
    );

    assign mode_o      = mode;
    assign op_size_o   = op_sz;
    assign addr_size_o = ad_sz;
    assign prot_en_o   = st.prot;
    assign page_en_o   = st.page;
    assign addr_ext_o  = st.ext;
    assign long_en_o   = st.lng;
    assign long_act_o  = st.act;

endmodule

// File: rtl/opmode_ctl_chk.sv
// Checker: temporal properties of the mode controller, bound to the top.
// Assumes: observes only top-level ports.
module opmode_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_l,
    input logic       cs_d,
    input logic       asz_ovr,
    input logic [1:0] mode_o,
    input logic [1:0] addr_size_o,
    input logic       mode_invalid_o,
    input logic       fault_o,
    input logic       prot_en_o,
    input logic       page_en_o,
    input logic       addr_ext_o,
    input logic       long_en_o,
    input logic       long_act_o
);

    // R3
    act_needs_paging_chk: assert property (@(posedge clk) disable iff (!rst_n)
        long_act_o |-> (page_en_o && long_en_o));

    // R4
    paging_needs_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_en_o |-> prot_en_o);

    // R5
    long_paging_needs_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_en_o && long_en_o) |-> addr_ext_o);

    // R6
    long_en_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(long_en_o) |-> !$past(page_en_o));

    // R7
    fault_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> ($stable(prot_en_o) && $stable(page_en_o) && $stable(addr_ext_o)
                     && $stable(long_en_o) && $stable(long_act_o)));

    // R8
    real_when_unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en_o |-> (mode_o == 2'd0));

    // R11
    wide_addr_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 2'd3) && !asz_ovr) |-> (addr_size_o == 2'd2));

    // R12
    invalid_only_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_invalid_o |-> (long_act_o && cs_l && cs_d));

endmodule

bind opmode_ctl opmode_ctl_chk u_opmode_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cs_l           (cs_l),
    .cs_d           (cs_d),
    .asz_ovr        (asz_ovr),
    .mode_o         (mode_o),
    .addr_size_o    (addr_size_o),
    .mode_invalid_o (mode_invalid_o),
    .fault_o        (fault_o),
    .prot_en_o      (prot_en_o),
    .page_en_o      (page_en_o),
    .addr_ext_o     (addr_ext_o),
    .long_en_o      (long_en_o),
    .long_act_o     (long_act_o)
);

// File: tb/opmode_ctl_test.sv
// Bench: scripted write sequence plus full sweeps of the decode inputs.
module opmode_ctl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [1:0] wr_data = '0;
    logic       cs_l = 1'b0, cs_d = 1'b0, osz_ovr = 1'b0, asz_ovr = 1'b0, wide_op = 1'b0;
    logic [1:0] mode_o, op_size_o, addr_size_o;
    logic       mode_invalid_o, fault_o;
    logic       prot_en_o, page_en_o, addr_ext_o, long_en_o, long_act_o;

    int checks = 0;
    int failures = 0;

    opmode_ctl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cs_l(cs_l), .cs_d(cs_d), .osz_ovr(osz_ovr), .asz_ovr(asz_ovr), .wide_op(wide_op),
        .mode_o(mode_o), .op_size_o(op_size_o), .addr_size_o(addr_size_o),
        .mode_invalid_o(mode_invalid_o), .fault_o(fault_o),
        .prot_en_o(prot_en_o), .page_en_o(page_en_o), .addr_ext_o(addr_ext_o),
        .long_en_o(long_en_o), .long_act_o(long_act_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // Expected {invalid, mode, op, addr} from the decode requirements.
    function automatic logic [6:0] exp_dec(input logic pe, input logic act, input logic l,
                                           input logic d, input logic o, input logic a,
                                           input logic w);
        logic [1:0] m, op, ad, base;
        logic inv;
        inv = 1'b0;
        if (!pe) begin
            m = 2'd0; op = o ? 2'd1 : 2'd0; ad = a ? 2'd1 : 2'd0;
        end else if (!act || !l) begin
            m = act ? 2'd2 : 2'd1;
            base = d ? 2'd1 : 2'd0;
            op = o ? (2'd1 - base) : base;
            ad = a ? (2'd1 - base) : base;
        end else begin
            m = 2'd3;
            op = w ? 2'd2 : (o ? 2'd0 : 2'd1);
            ad = a ? 2'd1 : 2'd2;
            inv = d;
        end
        return {inv, m, op, ad};
    endfunction

    task automatic sweep(input logic pe, input logic act);
        for (int i = 0; i < 32; i++) begin
            logic [6:0] exp, got;
            string req;
            @(negedge clk);
            {cs_l, cs_d, osz_ovr, asz_ovr, wide_op} = 5'(i);
            #1;
            exp = exp_dec(pe, act, cs_l, cs_d, osz_ovr, asz_ovr, wide_op);
            got = {mode_invalid_o, mode_o, op_size_o, addr_size_o};
            if (!pe) req = "R8";
            else if (!act) req = "R9";
            else if (!cs_l) req = "R10";
            else if (cs_d) req = "R12";
            else req = "R11";
            check(got == exp, req, got, exp);
        end
    endtask

    // Drive one write for one edge; returns half a cycle after that edge.
    task automatic wr(input logic [1:0] sel, input logic [1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Compare {prot,page,ext,long,act} and fault.
    task automatic chk_state(input logic [4:0] exp, input logic exp_fault, input string req);
        logic [4:0] got;
        got = {prot_en_o, page_en_o, addr_ext_o, long_en_o, long_act_o};
        check(got == exp, req, got, exp);
        check(fault_o == exp_fault, req, fault_o, exp_fault);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog got=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_state(5'b00000, 1'b0, "R1");
        check({mode_o, op_size_o, addr_size_o} == 6'd0, "R1",
              {mode_o, op_size_o, addr_size_o}, 0);
        rst_n = 1'b1;
        sweep(1'b0, 1'b0);

        // R4 / R7: paging without protection refused, pulse lasts one cycle
        wr(2'd0, 2'b10);
        chk_state(5'b00000, 1'b1, "R4");
        @(negedge clk);
        check(fault_o == 1'b0, "R7", fault_o, 0);

        // R2: enable protection
        wr(2'd0, 2'b01);
        chk_state(5'b10000, 1'b0, "R2");
        sweep(1'b1, 1'b0);

        // R2 / R3: long enable alone does not activate
        wr(2'd2, 2'b01);
        chk_state(5'b10010, 1'b0, "R3");
        sweep(1'b1, 1'b0);

        // R5: paging with long enable but no extension refused
        wr(2'd0, 2'b11);
        chk_state(5'b10010, 1'b1, "R5");

        wr(2'd1, 2'b01);
        chk_state(5'b10110, 1'b0, "R2");

        // R3: paging on with long enable activates
        wr(2'd0, 2'b11);
        chk_state(5'b11111, 1'b0, "R3");
        sweep(1'b1, 1'b1);

        // R6 / R7: refused changes while paging
        wr(2'd2, 2'b00);
        chk_state(5'b11111, 1'b1, "R6");
        wr(2'd1, 2'b00);
        chk_state(5'b11111, 1'b1, "R6");

        // R2: select 3 ignored
        wr(2'd3, 2'b11);
        chk_state(5'b11111, 1'b0, "R2");
        check(mode_o == 2'd3, "R2", mode_o, 3);

        // R3: clearing paging clears active at the same edge
        wr(2'd0, 2'b01);
        chk_state(5'b10110, 1'b0, "R3");

        // R6: accepted once paging is off
        wr(2'd2, 2'b00);
        chk_state(5'b10100, 1'b0, "R6");

        // R3: paging without long enable stays inactive
        wr(2'd0, 2'b11);
        chk_state(5'b11100, 1'b0, "R3");
        sweep(1'b1, 1'b0);

        // R2: back to real mode
        wr(2'd0, 2'b00);
        chk_state(5'b00100, 1'b0, "R2");
        sweep(1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule